// File: doc/BRIEF.md
# Frame Engine Control and Interrupt Register Block

This block is the register-mapped front end of a frame-processing engine. Software reaches it over a plain 32-bit register bus with a one-cycle write strobe and combinational read data. It gives software three controls. A control word launches a frame or starts a short internal soft reset. An event mask and a sticky event register feed a single level interrupt line. A watchdog with a prescaler flags a frame that never finishes.

The datapath reports back to the block in two ways. It sends a one-cycle frame-done pulse, and it drives a vector of parameter-error flags, one per illegal-setting check (colour format, base addresses, spans, sizes, positions, ratio, blend). Each of these, together with the watchdog expiry, owns one bit in the event mask and one in the sticky event register. Software clears events by writing back the value it read, because writing 1 to a bit clears it. A soft reset reads as busy for a fixed number of cycles. While it lasts, it empties the event register and the mask and halts the watchdog. A prescaler variant (linear or power-of-two) is chosen by parameter.

Top module: `engc_regs`

## Requirements
- R1: After the reset input is released, every register reads 0, `irq` is 0 and `start_pulse` is 0.
- R2: Writing 1 to bit 1 of the control word (word address 0) starts a soft reset. Bit 1 of the control word then reads 1 for exactly RST_CYCLES clock cycles after the write edge and reads 0 afterwards.
- R3: During a soft reset, the event register and the event mask are cleared and the watchdog stops. Mask writes and start commands issued while busy are ignored.
- R4: The event mask (word address 1) reads back exactly the written value in its low NEVT bits. Its upper bits read 0.
- R5: Writing 1 to bit 0 of the control word while not busy drives `start_pulse` high for the one cycle that follows the write edge. Bit 0 of the control word always reads 0.
- R6: The event register (word address 2) is sticky. Bit 0 is set by `frame_done`, bit 1 by watchdog expiry, and bit 2+i by `param_err[i]`.
- R7: Writing to the event register clears every bit written as 1. An event arriving in the same cycle as the clear leaves its bit set.
- R8: `irq` is 1 exactly when some event bit and its mask bit are both 1. Writing 0 to the mask drops `irq`.
- R9: The watchdog word (word address 3) has enable in bit 31, a divider in bits 19:16 and a timer value in bits 15:0. A start with the watchdog enabled sets event bit 1 exactly tval*(div+1) cycles after the start write edge. A tval of 0 behaves as 1.
- R10: A `frame_done` pulse arriving before expiry stops the watchdog, so no timeout event follows.
- R11: A start with the watchdog enable bit at 0 never produces a timeout event.
- R12: The watchdog word reads back only its enable, divider and timer fields, with other bits 0. Unmapped word addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| frame_done | input | 1 | One-cycle frame completion pulse from the datapath |
| param_err | input | NERR | Illegal-parameter flags from the datapath |
| irq | output | 1 | Level interrupt |
| start_pulse | output | 1 | One-cycle frame launch to the datapath |

## Verification
Several rules are checked by assertions on every cycle: the soft-reset countdown stays in bounds and ends from a count of one, a busy cycle empties the mask and the event register, events stick, a write-one clear takes effect unless an event arrives with it, and an expiry or a frame-done halts the watchdog. Other behaviour shows only in the bench's scenarios, because it spans many cycles or depends on register values reaching the ports. This covers the exact busy length seen through readback, the expiry cycle for a given timer and divider, a start or mask write swallowed during reset, and the interrupt following random mixes of mask writes, events and clears.

// File: rtl/engc_pkg.sv
package engc_pkg;

   typedef enum logic [1:0] {
      REG_CTRL  = 2'd0,
      REG_IMASK = 2'd1,
      REG_EVT   = 2'd2,
      REG_WDOG  = 2'd3
   } reg_sel_e;

   localparam int CTRL_START_BIT = 0;
   localparam int CTRL_SRST_BIT  = 1;

   localparam int EVT_FEND_BIT = 0;
   localparam int EVT_TMO_BIT  = 1;
   localparam int EVT_ERR_LSB  = 2;

   localparam int WD_TVAL_W   = 16;
   localparam int WD_DIV_W    = 4;
   localparam int WD_DIV_LSB  = 16;
   localparam int WD_EN_BIT   = 31;

   typedef struct packed {
      logic                 en;
      logic [WD_DIV_W-1:0]  div;
      logic [WD_TVAL_W-1:0] tval;
   } wdog_cfg_t;

endpackage

// File: rtl/engc_srst_seq.sv
module engc_srst_seq #(
   parameter int RST_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic busy
);
   localparam int CNT_W = $clog2(RST_CYCLES + 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (req)
         cnt <= CNT_W'(RST_CYCLES);
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(RST_CYCLES));

   // R2
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (cnt == CNT_W'(RST_CYCLES)));

   // R2
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(cnt) == CNT_W'(1)));

endmodule

// File: rtl/engc_irq_unit.sv
module engc_irq_unit #(
   parameter int NEVT = 18
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic            en_we,
   input  logic [NEVT-1:0] en_wdata,
   input  logic            clr_we,
   input  logic [NEVT-1:0] clr_mask,
   input  logic [NEVT-1:0] evt,
   output logic [NEVT-1:0] en_q,
   output logic [NEVT-1:0] stat_q,
   output logic            irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en_q <= '0;
      else if (flush)
         en_q <= '0;
      else if (en_we)
         en_q <= en_wdata;
   end

   for (genvar i = 0; i < NEVT; i++) begin : g_evt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stat_q[i] <= 1'b0;
         else if (flush)
            stat_q[i] <= 1'b0;
         else
            stat_q[i] <= (stat_q[i] & ~(clr_we & clr_mask[i])) | evt[i];
      end
   end

   assign irq = |(stat_q & en_q);

   // R3
   flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (stat_q == '0 && en_q == '0));

   // R6
   evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> ((stat_q & $past(evt)) == $past(evt)));

   // R7
   clr_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !flush) |=> ((stat_q & $past(clr_mask & ~evt)) == '0));

   // R8
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq);

endmodule

// File: rtl/engc_wdog.sv
module engc_wdog
   import engc_pkg::*;
#(
   parameter bit PRESCALE_POW2 = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      flush,
   input  logic      start,
   input  logic      stop,
   input  wdog_cfg_t cfg,
   output logic      timeout
);
   localparam int PRE_W = PRESCALE_POW2 ? (1 << WD_DIV_W) - 1 : WD_DIV_W;

   logic                 running;
   logic [WD_TVAL_W-1:0] cnt;
   logic [PRE_W-1:0]     pre;
   logic [PRE_W-1:0]     pre_lim;
   logic                 tick;
   logic                 last;

   if (PRESCALE_POW2) begin : g_pow2
      assign pre_lim = (PRE_W'(1) << cfg.div) - 1'b1;
   end else begin : g_lin
      assign pre_lim = PRE_W'(cfg.div);
   end

   assign tick    = running && (pre == pre_lim);
   assign last    = (cnt <= WD_TVAL_W'(1));
   assign timeout = tick && last && !start && !stop && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
         pre     <= '0;
      end else if (flush) begin
         running <= 1'b0;
         cnt     <= '0;
         pre     <= '0;
      end else if (start) begin
         running <= cfg.en;
         cnt     <= cfg.tval;
         pre     <= '0;
      end else if (stop) begin
         running <= 1'b0;
      end else if (running) begin
         if (tick) begin
            pre <= '0;
            if (last)
               running <= 1'b0;
            else
               cnt <= cnt - 1'b1;
         end else begin
            pre <= pre + 1'b1;
         end
      end
   end

   // R9
   tmo_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !running);

   // R10
   stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start) |=> !running);

   // R11
   off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !cfg.en && !flush) |=> !running);

   // R3
   flush_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !running);

endmodule

// File: rtl/engc_regs.sv
module engc_regs
   import engc_pkg::*;
#(
   parameter int ADDR_W        = 4,
   parameter int DATA_W        = 32,
   parameter int NERR          = 16,
   parameter int RST_CYCLES    = 8,
   parameter bit PRESCALE_POW2 = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              frame_done,
   input  logic [NERR-1:0]   param_err,
   output logic              irq,
   output logic              start_pulse
);
   localparam int NEVT = NERR + EVT_ERR_LSB;

   if (ADDR_W < 3) begin : g_bad_addr
      $error("engc_regs: ADDR_W must be at least 3");
   end
   if (DATA_W < 32) begin : g_bad_data
      $error("engc_regs: DATA_W must be at least 32");
   end
   if (NEVT > DATA_W) begin : g_bad_nevt
      $error("engc_regs: too many event bits for DATA_W");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("engc_regs: RST_CYCLES must be at least 1");
   end

   logic      mapped;
   reg_sel_e  sel;
   logic      busy;
   logic      wr_ctrl, srst_req, start_req;
   logic      en_we, clr_we;
   logic      tmo;
   wdog_cfg_t wd_cfg;
   logic [NEVT-1:0] evt, en_q, stat_q;

   assign mapped = (bus_addr[ADDR_W-1:2] == '0);
   assign sel    = reg_sel_e'(bus_addr[1:0]);

   assign wr_ctrl   = bus_wr && mapped && (sel == REG_CTRL);
   assign srst_req  = wr_ctrl && bus_wdata[CTRL_SRST_BIT] && !busy;
   assign start_req = wr_ctrl && bus_wdata[CTRL_START_BIT] && !busy && !srst_req;
   assign en_we     = bus_wr && mapped && (sel == REG_IMASK) && !busy;
   assign clr_we    = bus_wr && mapped && (sel == REG_EVT) && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_cfg      <= '0;
         start_pulse <= 1'b0;
      end else begin
         start_pulse <= start_req;
         if (bus_wr && mapped && (sel == REG_WDOG)) begin
            wd_cfg.en   <= bus_wdata[WD_EN_BIT];
            wd_cfg.div  <= bus_wdata[WD_DIV_LSB +: WD_DIV_W];
            wd_cfg.tval <= bus_wdata[WD_TVAL_W-1:0];
         end
      end
   end

   engc_srst_seq #(
      .RST_CYCLES(RST_CYCLES)
   ) u_srst (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (srst_req),
      .busy (busy)
   );

   engc_wdog #(
      .PRESCALE_POW2(PRESCALE_POW2)
   ) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (busy),
      .start  (start_req),
      .stop   (frame_done),
      .cfg    (wd_cfg),
      .timeout(tmo)
   );

   assign evt = {param_err, tmo, frame_done};

   engc_irq_unit #(
      .NEVT(NEVT)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (busy),
      .en_we   (en_we),
      .en_wdata(bus_wdata[NEVT-1:0]),
      .clr_we  (clr_we),
      .clr_mask(bus_wdata[NEVT-1:0]),
      .evt     (evt),
      .en_q    (en_q),
      .stat_q  (stat_q),
      .irq     (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (mapped) begin
         unique case (sel)
            REG_CTRL:  bus_rdata[CTRL_SRST_BIT] = busy;
            REG_IMASK: bus_rdata[NEVT-1:0] = en_q;
            REG_EVT:   bus_rdata[NEVT-1:0] = stat_q;
            REG_WDOG: begin
               bus_rdata[WD_EN_BIT]                = wd_cfg.en;
               bus_rdata[WD_DIV_LSB +: WD_DIV_W]  = wd_cfg.div;
               bus_rdata[WD_TVAL_W-1:0]           = wd_cfg.tval;
            end
            default: bus_rdata = '0;
         endcase
      end
   end

   // R5
   no_start_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> !busy);

endmodule

// File: tb/sim_engc_regs.sv
module sim_engc_regs;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 32;
   localparam int NERR   = 16;
   localparam int NEVT   = NERR + 2;
   localparam int RSTC   = 8;
   localparam logic [31:0] EMASK = 32'((64'd1 << NEVT) - 1);
   localparam logic [ADDR_W-1:0] A_CTRL = 0, A_MASK = 1, A_EVT = 2, A_WDOG = 3;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              bus_wr;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata;
   logic [DATA_W-1:0] bus_rdata;
   logic              frame_done;
   logic [NERR-1:0]   param_err;
   logic              irq;
   logic              start_pulse;

   always #5 clk = ~clk;

   engc_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NERR(NERR), .RST_CYCLES(RSTC),
      .PRESCALE_POW2(1'b0)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done),
      .param_err(param_err), .irq(irq), .start_pulse(start_pulse)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int sp_cnt = 0;
   logic [NEVT-1:0] m_en, m_stat;

   always @(negedge clk) if (start_pulse) sp_cnt++;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   function automatic logic exp_irq();
      return |(m_en & m_stat);
   endfunction

   task automatic pulse(logic fd, logic [NERR-1:0] pe);
      @(negedge clk);
      frame_done = fd; param_err = pe;
      @(negedge clk);
      frame_done = 1'b0; param_err = '0;
      m_stat |= {pe, 1'b0, fd};
   endtask

   task automatic clr_with_evt(logic [31:0] mask, logic [NERR-1:0] pe);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = A_EVT; bus_wdata = mask; param_err = pe;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0; param_err = '0;
      m_stat = (m_stat & ~mask[NEVT-1:0]) | {pe, 2'b00};
   endtask

   task automatic clear_all();
      wr(A_EVT, 32'hFFFF_FFFF);
      m_stat = '0;
   endtask

   initial begin
      #1_500_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int busy_n;
      int sp0;
      void'($urandom(32'd20240917));
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      frame_done = 1'b0; param_err = '0;
      m_en = '0; m_stat = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         rd(ADDR_W'(a), d);
         check("R1 reg after reset", d, 32'h0);
      end
      check("R1 irq after reset", {31'b0, irq}, 32'h0);
      check("R1 start_pulse after reset", {31'b0, start_pulse}, 32'h0);

      // R2 busy length through readback
      wr(A_MASK, 32'h3);
      pulse(1'b1, '0);
      wr(A_CTRL, 32'h2);
      busy_n = 0;
      for (int k = 0; k < 40; k++) begin
         rd(A_CTRL, d);
         if (!d[1]) break;
         busy_n++;
         @(negedge clk);
      end
      check("R2 busy cycles", 32'(busy_n), 32'(RSTC));
      m_en = '0; m_stat = '0;
      // R3 state cleared by soft reset
      rd(A_EVT, d);  check("R3 events cleared", d, 32'h0);
      rd(A_MASK, d); check("R3 mask cleared", d, 32'h0);

      // R3 writes ignored while busy
      sp0 = sp_cnt;
      wr(A_CTRL, 32'h2);
      wr(A_MASK, 32'hFF);
      wr(A_CTRL, 32'h1);
      repeat (RSTC + 2) @(negedge clk);
      check("R3 start ignored while busy", 32'(sp_cnt - sp0), 32'h0);
      rd(A_MASK, d); check("R3 mask write ignored while busy", d, 32'h0);

      // R4 mask alive after reset
      wr(A_MASK, 32'h1);
      rd(A_MASK, d); check("R4 mask readback", d, 32'h1);
      m_en = 1;

      // R5 start pulse
      wr(A_CTRL, 32'h1);
      check("R5 start high after write", {31'b0, start_pulse}, 32'h1);
      @(negedge clk);
      check("R5 start single cycle", {31'b0, start_pulse}, 32'h0);
      rd(A_CTRL, d); check("R5 control reads 0", d, 32'h0);

      // R12 watchdog word readback and unmapped address
      wr(A_WDOG, 32'hFFFF_FFFF);
      rd(A_WDOG, d); check("R12 watchdog readback", d, 32'h800F_FFFF);
      rd(ADDR_W'(7), d); check("R12 unmapped read", d, 32'h0);
      wr(A_WDOG, 32'h0);
      clear_all();

      // R8 directed: zero mask drops irq
      pulse(1'b1, 16'h0001);
      wr(A_MASK, EMASK);
      m_en = EMASK[NEVT-1:0];
      check("R8 irq with full mask", {31'b0, irq}, {31'b0, exp_irq()});
      wr(A_MASK, 32'h0);
      m_en = '0;
      check("R8 irq after zero mask", {31'b0, irq}, 32'h0);

      // R7 directed: event arriving with its clear stays set
      clr_with_evt(32'hFFFF_FFFF, 16'h0004);
      rd(A_EVT, d); check("R7 set wins over clear", d, 32'h0000_0010);

      // random mix: R4 R6 R7 R8
      for (int it = 0; it < 400; it++) begin
         int op;
         logic [31:0] r;
         op = $urandom_range(0, 3);
         r  = $urandom;
         case (op)
            0: begin
               wr(A_MASK, r);
               m_en = r[NEVT-1:0];
               rd(A_MASK, d); check("R4 mask readback random", d, r & EMASK);
            end
            1: pulse(r[31], NERR'(r[15:0] & $urandom & $urandom));
            2: begin
               wr(A_EVT, r);
               m_stat &= ~r[NEVT-1:0];
            end
            default: clr_with_evt(r, NERR'($urandom & $urandom));
         endcase
         rd(A_EVT, d); check("R6 R7 event register", d, {{(32-NEVT){1'b0}}, m_stat});
         check("R8 irq random", {31'b0, irq}, {31'b0, exp_irq()});
      end

      // R9 expiry timing tval=5 div=2
      clear_all();
      wr(A_MASK, 32'h2); m_en = 2;
      wr(A_WDOG, 32'h8002_0005);
      wr(A_CTRL, 32'h1);
      repeat (14) @(negedge clk);
      rd(A_EVT, d); check("R9 no timeout one cycle early", d, 32'h0);
      @(negedge clk);
      rd(A_EVT, d); check("R9 timeout at tval*(div+1)", d, 32'h2);
      check("R9 R8 irq on timeout", {31'b0, irq}, 32'h1);

      // R9 tval 0 acts as 1
      clear_all();
      wr(A_WDOG, 32'h8000_0000);
      wr(A_CTRL, 32'h1);
      rd(A_EVT, d); check("R9 tval0 not yet", d, 32'h0);
      @(negedge clk);
      rd(A_EVT, d); check("R9 tval0 expires after one cycle", d, 32'h2);

      // R10 frame_done stops watchdog
      clear_all();
      wr(A_WDOG, 32'h8000_0014);
      wr(A_CTRL, 32'h1);
      repeat (4) @(negedge clk);
      pulse(1'b1, '0);
      repeat (40) @(negedge clk);
      rd(A_EVT, d); check("R10 frame end, no timeout", d, 32'h1);

      // R11 disabled watchdog
      clear_all();
      wr(A_WDOG, 32'h0000_0003);
      wr(A_CTRL, 32'h1);
      repeat (20) @(negedge clk);
      rd(A_EVT, d); check("R11 disabled watchdog silent", d, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule